// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a two-wire serial slave that gives a host access to a bank of 8-bit configuration registers reached through a 6-bit register pointer. The block samples the clock and data lines with its own system clock, so it needs no second clock domain. It detects START, repeated START and STOP, compares the 7-bit device address with a parameter, and drives the data line low to acknowledge each byte it accepts. The host sees the open-drain data line as `sda_i`. The slave only ever asks for the line to be pulled low through `sda_oe_o`.

After its device address with the write direction, the slave takes a pointer byte. Bit 7 of the pointer byte chooses the write style. When bit 7 is clear, every data byte must be preceded by its own pointer byte. When bit 7 is set, one pointer byte is followed by a burst that fills successive registers. A read is a pointer write followed by a repeated START with the read direction. It starts at the pointer and steps forward after each byte when the auto-increment flag is set.

At reset, a few register bits take their values from seven strap inputs. Most of these straps are inverted. A register bit acts as an active-low software reset, and it reloads the same captured strap values.

Top module: `cfgbus_slave`

## Requirements
- R1: After reset, the register bits take these strap values. Register 00h bit 0 equals strap 6. Register 01h bit 0 equals the inverse of strap 5. Register 01h bit 1 equals the inverse of strap 4. Register 02h bits 3:0 equal the inverse of straps 3:0. Every other bit of registers 00h to 1Fh is 0, and `sda_oe_o` is low.
- R2: The straps are captured once, on the first clock after the internal reset releases. Later strap changes affect neither the registers nor a later software-reset reload.
- R3: A byte after START whose upper 7 bits equal `DEV_ADDR` (default 3Ah) is acknowledged, and its bit 0 selects read (1) or write (0). Any other device address is not acknowledged, and the rest of that transaction changes no register.
- R4: Every accepted byte is acknowledged by driving the data line low through the whole ninth clock. This applies to the device address, pointer bytes and data bytes, including data bytes sent to ignored addresses.
- R5: When pointer-byte bit 7 is 0, one data byte is written to the register named by bits 5:0. The next byte is then treated as a new pointer byte.
- R6: When pointer-byte bit 7 is 1, the data bytes that follow are written to successive registers. The pointer wraps from 3Fh to 00h.
- R7: A read after a repeated START returns the register at the pointer, most significant bit first. With auto-increment set, each byte sent advances the pointer. Without it, the same register repeats. After a master not-acknowledge, the slave releases the line until the next START.
- R8: Register 26h reads back the current 6-bit pointer in bits 5:0. Writes to register 26h are acknowledged and have no effect.
- R9: Register 24h reads as 10h. Writing it with bit 4 at 0 returns registers 00h to 1Fh to their strap-derived defaults. Writing it with bit 4 at 1 has no effect.
- R10: Writes to addresses 20h to 3Fh, other than 24h, change no register. Reads of addresses other than 00h to 1Fh, 24h and 26h return 00h.
- R11: A STOP returns the slave to idle, and it never drives the data line while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as resolved on the wire |
| straps_i | input | 7 | Strap levels that set some reset defaults |
| sda_oe_o | output | 1 | High to pull the data line low |
| cfg_o | output | 8*N_RW | Registers 00h upward, register n in bits 8n+7:8n |

## Verification
The assertions assume a well-formed bus. Each clock phase lasts many system clocks. Data changes only while the clock is low, except at START and STOP. The master never issues START or STOP while the slave holds the line low. The bench holds each quarter bit for six system clocks and moves data only after the slave has had time to release the line. It issues every START and STOP from a released line. Under these conditions the assertions can rely on several facts: the slave's drive changes only during clock-low phases, a register write that advances the pointer moves it by exactly one, and ignored writes leave the register outputs unchanged.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
  localparam int unsigned AW = 6;
  localparam int unsigned DW = 8;
  localparam logic [AW-1:0] REG_SRST = 6'h24;
  localparam logic [AW-1:0] REG_PTR  = 6'h26;
  localparam int unsigned SRST_BIT = 4;
  localparam int unsigned N_STRAP = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } bus_st_e;
endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe_q[STAGES-1] is the synchronized level, pipe_q[STAGES] the previous one
  logic [STAGES:0] pipe_q, pipe_d;

  always_comb pipe_d = {pipe_q[STAGES-1:0], d_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= pipe_d;
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/cfgbus_regbank.sv
module cfgbus_regbank
  import cfgbus_pkg::*;
#(
  parameter int unsigned N_RW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STRAP-1:0] straps_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic [DW*N_RW-1:0] cfg_o
);
  logic               strap_done_q;
  logic [N_STRAP-1:0] strap_q, strap_d;
  logic               soft_rst, load_dflt;

  function automatic logic [DW-1:0] dflt(input int unsigned idx, input logic [N_STRAP-1:0] s);
    logic [DW-1:0] v;
    v = '0;
    case (idx)
      0: v[0]   = s[6];
      1: v[1:0] = {~s[4], ~s[5]};
      2: v[3:0] = ~s[3:0];
      default: v = '0;
    endcase
    return v;
  endfunction

  assign soft_rst  = wr_en_i && (wr_addr_i == REG_SRST) && !wr_data_i[SRST_BIT];
  assign load_dflt = !strap_done_q || soft_rst;
  assign strap_d   = strap_done_q ? strap_q : straps_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strap_done_q <= 1'b0;
      strap_q      <= '0;
    end else if (!strap_done_q) begin
      strap_done_q <= 1'b1;
      strap_q      <= strap_d;
    end
  end

  for (genvar i = 0; i < N_RW; i++) begin : g_reg
    localparam logic [AW-1:0] IDX = AW'(i);
    logic [DW-1:0] val_q, val_d;
    logic          en;

    always_comb begin
      en    = load_dflt || (wr_en_i && (wr_addr_i == IDX));
      val_d = load_dflt ? dflt(i, strap_d) : wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  val_q <= '0;
      else if (en)  val_q <= val_d;
    end

    assign cfg_o[i*DW +: DW] = val_q;
  end

  always_comb begin
    rd_data_o = '0;
    for (int unsigned i = 0; i < N_RW; i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o = cfg_o[i*DW +: DW];
    end
    if (rd_addr_i == REG_SRST) rd_data_o = DW'(1) << SRST_BIT;
    if (rd_addr_i == REG_PTR)  rd_data_o = {{(DW-AW){1'b0}}, rd_addr_i};
  end
endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          sda_rise_i,
  input  logic          sda_fall_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          sda_oe_o
);
  localparam logic [3:0] LAST_BIT = 4'd8;

  bus_st_e       st_q, st_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          drv_q, drv_d, rw_q, rw_d, exp_q, exp_d;
  logic          ainc_q, ainc_d, mack_q, mack_d, wen_q, wen_d;
  logic [AW-1:0] ptr_q, ptr_d, wadr_q, wadr_d;
  logic [DW-1:0] wdat_q, wdat_d;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; drv_d = drv_q; rw_d = rw_q;
    exp_d = exp_q; ainc_d = ainc_q; ptr_d = ptr_q; mack_d = mack_q;
    wen_d = 1'b0; wadr_d = wadr_q; wdat_d = wdat_q;
    if (sda_fall_i && scl_lvl_i) begin          // START or repeated START
      st_d = ST_DEV; cnt_d = '0; drv_d = 1'b0;
    end else if (sda_rise_i && scl_lvl_i) begin // STOP
      st_d = ST_IDLE; drv_d = 1'b0;
    end else begin
      case (st_q)
        ST_DEV, ST_WR: begin
          if (scl_rise_i && cnt_q != LAST_BIT) begin
            sh_d  = {sh_q[DW-2:0], sda_lvl_i};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall_i && cnt_q == LAST_BIT) begin
            if (st_q == ST_DEV) begin
              if (sh_q[7:1] == DEV_ADDR) begin
                drv_d = 1'b1; rw_d = sh_q[0]; exp_d = 1'b1; st_d = ST_DACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              drv_d = 1'b1; st_d = ST_WACK;
              if (exp_q) begin
                ptr_d = sh_q[AW-1:0]; ainc_d = sh_q[7]; exp_d = 1'b0;
              end else begin
                wen_d = 1'b1; wadr_d = ptr_q; wdat_d = sh_q;
                if (ainc_q) ptr_d = ptr_q + 6'd1;
                else        exp_d = 1'b1;
              end
            end
          end
        end
        ST_DACK, ST_WACK, ST_RACK: begin
          if (st_q == ST_RACK && scl_rise_i) mack_d = ~sda_lvl_i;
          if (scl_fall_i) begin
            if ((st_q == ST_DACK && rw_q) || (st_q == ST_RACK && mack_q)) begin
              sh_d = {rd_data_i[DW-2:0], 1'b0}; drv_d = ~rd_data_i[DW-1];
              cnt_d = 4'd1; st_d = ST_RD;
            end else if (st_q == ST_RACK) begin
              drv_d = 1'b0; st_d = ST_IDLE;
            end else begin
              drv_d = 1'b0; cnt_d = '0; st_d = ST_WR;
            end
          end
        end
        ST_RD: begin
          if (scl_fall_i) begin
            if (cnt_q == LAST_BIT) begin
              drv_d = 1'b0; st_d = ST_RACK;
              if (ainc_q) ptr_d = ptr_q + 6'd1;
            end else begin
              drv_d = ~sh_q[DW-1]; sh_d = {sh_q[DW-2:0], 1'b0}; cnt_d = cnt_q + 4'd1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; drv_q <= 1'b0; rw_q <= 1'b0;
      exp_q <= 1'b1; ainc_q <= 1'b0; ptr_q <= '0; mack_q <= 1'b0;
      wen_q <= 1'b0; wadr_q <= '0; wdat_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; drv_q <= drv_d; rw_q <= rw_d;
      exp_q <= exp_d; ainc_q <= ainc_d; ptr_q <= ptr_d; mack_q <= mack_d;
      wen_q <= wen_d; wadr_q <= wadr_d; wdat_q <= wdat_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wen_q;
  assign wr_addr_o = wadr_q;
  assign wr_data_o = wdat_q;
  assign sda_oe_o  = drv_q;
endmodule

// File: rtl/cfgbus_slave.sv
module cfgbus_slave
  import cfgbus_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h3A,
  parameter int unsigned N_RW        = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic [N_STRAP-1:0]   straps_i,
  output logic                 sda_oe_o,
  output logic [DW*N_RW-1:0]   cfg_o
);
  logic          rst_meta_q, rst_n;
  logic          scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic [AW-1:0] ptr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {rst_n, rst_meta_q} <= 2'b00;
    else         {rst_n, rst_meta_q} <= {rst_meta_q, 1'b1};
  end

  cfgbus_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  cfgbus_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
    .clk_i(clk_i), .rst_ni(rst_n), .d_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  cfgbus_ctrl #(.DEV_ADDR(DEV_ADDR)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_n),
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .rd_data_i(rd_data), .ptr_o(ptr), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_oe_o(sda_oe_o));

  cfgbus_regbank #(.N_RW(N_RW)) bank_i (
    .clk_i(clk_i), .rst_ni(rst_n), .straps_i(straps_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .rd_data_o(rd_data), .cfg_o(cfg_o));
endmodule

// File: rtl/cfgbus_slave_chk.sv
module cfgbus_slave_chk
  import cfgbus_pkg::*;
#(
  parameter int unsigned N_RW = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               scl_lvl,
  input logic               sda_oe,
  input bus_st_e            st,
  input logic               strap_done,
  input logic [N_STRAP-1:0] strap_q,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [AW-1:0]      ptr,
  input logic               ainc,
  input logic               soft_rst,
  input logic [DW*N_RW-1:0] cfg
);
  localparam logic [AW-1:0] N_RW_A = AW'(N_RW);

  // R2: once captured, the strap shadow never changes again
  p_strap_frozen_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strap_done |=> (strap_done && $stable(strap_q)));

  // R4: the slave changes its drive only while the clock line is low
  p_drive_low_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

  // R6: a burst data write leaves the pointer one past the written register
  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && ainc) |-> (ptr == wr_addr + 6'd1));

  // R9: a software reset clears a plain register on the next cycle
  p_soft_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (cfg[3*DW +: DW] == '0));

  // R10: writes outside the register file and the reset register are ignored
  p_ignored_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= N_RW_A && wr_addr != REG_SRST) |=> $stable(cfg));

  // R11: no drive while idle
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe);
endmodule

bind cfgbus_slave cfgbus_slave_chk #(.N_RW(N_RW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe_o),
  .st(ctrl_i.st_q), .strap_done(bank_i.strap_done_q), .strap_q(bank_i.strap_q),
  .wr_en(wr_en), .wr_addr(wr_addr), .ptr(ctrl_i.ptr_q), .ainc(ctrl_i.ainc_q),
  .soft_rst(bank_i.soft_rst), .cfg(cfg_o));

// File: tb/cfgbus_slave_tb.sv
module cfgbus_slave_tb_top;
  localparam int N_RW = 32;
  localparam int Q = 6;
  localparam logic [7:0] DW_ADDR = 8'h74;  // 3Ah, write
  localparam logic [7:0] DR_ADDR = 8'h75;  // 3Ah, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic [6:0] straps = 7'b1010110;
  logic sda_oe;
  logic [8*N_RW-1:0] cfg;
  logic sda_line;
  int checks = 0;
  int errors = 0;

  assign sda_line = m_sda & ~sda_oe;
  always #4 clk = ~clk;

  cfgbus_slave #(.DEV_ADDR(7'h3A), .N_RW(N_RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line),
    .straps_i(straps), .sda_oe_o(sda_oe), .cfg_o(cfg));

  function automatic logic [7:0] rg(input int idx);
    return cfg[idx*8 +: 8];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); ack = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
    end
    m_sda = ~give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); m_sda = 1'b1;
  endtask

  task automatic put(input string req, input logic [7:0] b);
    logic a;
    send_byte(b, a);
    chk(req, a, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 reg00", rg(0), 8'h01);
    chk("R1 reg01", rg(1), 8'h01);
    chk("R1 reg02", rg(2), 8'h09);
    chk("R1 reg03", rg(3), 8'h00);
    chk("R1 sda_oe", sda_oe, 1'b0);
  endtask

  task automatic t_strap_late();
    straps = 7'b0101001; wq(20);
    chk("R2 reg00 after strap change", rg(0), 8'h01);
    chk("R2 reg02 after strap change", rg(2), 8'h09);
  endtask

  task automatic t_write_alt();
    bus_start();
    put("R3 R4 dev addr ack", DW_ADDR);
    put("R4 ptr ack", 8'h03); put("R4 data ack", 8'hA5);
    put("R5 ptr ack", 8'h07); put("R5 data ack", 8'h3C);
    bus_stop();
    chk("R5 reg03", rg(3), 8'hA5);
    chk("R5 reg07", rg(7), 8'h3C);
    chk("R5 reg04 untouched", rg(4), 8'h00);
    chk("R11 idle after stop", sda_oe, 1'b0);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'h76, a);
    chk("R3 nack wrong addr", a, 1'b1);
    send_byte(8'h03, a); send_byte(8'hFF, a);
    bus_stop();
    chk("R3 reg03 kept", rg(3), 8'hA5);
  endtask

  task automatic t_burst();
    bus_start();
    put("R6 dev", DW_ADDR); put("R6 ptr", 8'h90);
    put("R6 d0", 8'h11); put("R6 d1", 8'h22); put("R6 d2", 8'h33);
    bus_stop();
    chk("R6 reg10", rg(16), 8'h11);
    chk("R6 reg11", rg(17), 8'h22);
    chk("R6 reg12", rg(18), 8'h33);
    chk("R6 reg13 untouched", rg(19), 8'h00);
  endtask

  task automatic t_wrap();
    bus_start();
    put("R6 dev", DW_ADDR); put("R6 ptr 3F", 8'hBF);
    put("R6 data to 3F", 8'h77); put("R6 data wraps to 00", 8'h5A);
    bus_stop();
    chk("R6 wrap reg00", rg(0), 8'h5A);
  endtask

  task automatic t_read_burst();
    logic [7:0] b;
    bus_start(); put("R7 dev", DW_ADDR); put("R7 ptr", 8'h90);
    bus_start(); put("R7 dev read", DR_ADDR);
    recv_byte(1'b1, b); chk("R7 read 10h", b, 8'h11);
    recv_byte(1'b1, b); chk("R7 read 11h", b, 8'h22);
    recv_byte(1'b0, b); chk("R7 read 12h", b, 8'h33);
    chk("R7 released after nack", sda_oe, 1'b0);
    bus_stop();
  endtask

  task automatic t_read_noinc();
    logic [7:0] b;
    bus_start(); put("R7 dev", DW_ADDR); put("R7 ptr", 8'h03);
    bus_start(); put("R7 dev read", DR_ADDR);
    recv_byte(1'b1, b); chk("R7 read 03h", b, 8'hA5);
    recv_byte(1'b0, b); chk("R7 repeat 03h", b, 8'hA5);
    bus_stop();
  endtask

  task automatic t_ptr();
    logic [7:0] b;
    bus_start(); put("R8 dev", DW_ADDR);
    put("R8 ptr 26", 8'h26); put("R8 write 26 acked", 8'h99); put("R8 ptr 26 again", 8'h26);
    bus_start(); put("R8 dev read", DR_ADDR);
    recv_byte(1'b0, b); chk("R8 read 26h", b, 8'h26);
    bus_stop();
    bus_start(); put("R8 dev", DW_ADDR); put("R8 ptr 25 inc", 8'hA5);
    bus_start(); put("R8 dev read", DR_ADDR);
    recv_byte(1'b1, b); chk("R10 read 25h", b, 8'h00);
    recv_byte(1'b0, b); chk("R8 read pointer after step", b, 8'h26);
    bus_stop();
  endtask

  task automatic t_unimpl();
    logic [7:0] b;
    bus_start(); put("R10 dev", DW_ADDR); put("R10 ptr 30", 8'h30); put("R10 data acked", 8'hFF);
    put("R10 ptr 30 again", 8'h30);
    bus_start(); put("R10 dev read", DR_ADDR);
    recv_byte(1'b0, b); chk("R10 read 30h", b, 8'h00);
    bus_stop();
    chk("R10 reg03 kept", rg(3), 8'hA5);
  endtask

  task automatic t_soft_reset();
    logic [7:0] b;
    bus_start(); put("R9 dev", DW_ADDR); put("R9 ptr 24", 8'h24);
    bus_start(); put("R9 dev read", DR_ADDR);
    recv_byte(1'b0, b); chk("R9 read 24h", b, 8'h10);
    bus_stop();
    bus_start(); put("R9 dev", DW_ADDR); put("R9 ptr", 8'h24); put("R9 bit4 high", 8'h10);
    bus_stop();
    chk("R9 no reset with bit4 high", rg(3), 8'hA5);
    bus_start(); put("R9 dev", DW_ADDR); put("R9 ptr", 8'h24); put("R9 bit4 low", 8'h00);
    bus_stop();
    chk("R9 reg03 cleared", rg(3), 8'h00);
    chk("R9 reg10 cleared", rg(16), 8'h00);
    chk("R2 reg00 uses captured strap", rg(0), 8'h01);
    chk("R2 reg01 uses captured strap", rg(1), 8'h01);
    chk("R2 reg02 uses captured strap", rg(2), 8'h09);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wq(5); rst_n = 1'b1; wq(10);
    t_reset();
    t_strap_late();
    t_write_alt();
    t_wrong_addr();
    t_burst();
    t_wrap();
    t_read_burst();
    t_read_noinc();
    t_ptr();
    t_unimpl();
    t_soft_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule